// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches up to 93 general-purpose input pins and turns selected activity on them into one interrupt line for a host. The pins are grouped in 32-bit banks. For each pin, software chooses between edge and level detection. In edge mode, rising and falling transitions can each be enabled. In level mode, software picks the active polarity and can block the pin with a level mask. Every detected event sets a sticky per-pin status bit. Software clears a status bit by writing a one to it. A separate per-pin interrupt mask decides whether a set status bit contributes to the combined output.

Software reaches the block through a single-cycle word register port. A write takes effect at the clock edge where it is presented. A read returns data combinationally from the addressed word. The word address has two fields: its upper five bits select a register family and its lower two bits select the bank within that family. Each pin input passes through a two-flop synchronizer before detection, so asynchronous pad signals may be connected directly.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every status bit is 0 and `irq_o` is 0. For every valid pin bit, the rising-disable, falling-disable, level-mask and interrupt-mask registers read 1, and the mode and polarity registers read 0.
- R2: `reg_addr[6:2]` selects the family and `reg_addr[1:0]` selects the bank. The family codes are: mode 0x08, rising-disable 0x09, falling-disable 0x0A, level polarity 0x0B, level mask 0x0C, status 0x0D, interrupt mask 0x10. Any other family, and bank 3, read as zero and ignore writes. A configuration register reads back the last value written to its valid bits.
- R3: Bits 29..31 of bank 2 are not pins. They read as zero in every family and never set status.
- R4: With mode 0 and the rising-disable bit at 0, a low-to-high change on the pin sets that pin's status bit, and no other status bit, within four clocks.
- R5: With mode 0 and the falling-disable bit at 0, a high-to-low change sets the status bit. When both disable bits are 0, both directions set it.
- R6: In edge mode, a transition whose direction-disable bit is 1 leaves status unchanged.
- R7: With mode 1 and level mask 0, status sets while the synchronized pin equals the active level: high when polarity is 0, low when polarity is 1. With level mask 1, a level never sets status.
- R8: In level mode, status sets again on every clock while the active level persists. A write that clears the bit while the level is still present leaves it set, because a hardware set in the same cycle as a clear wins. Once the level is gone, the clear takes effect.
- R9: Writing status with a data bit of 1 clears that bit. Data bits of 0 leave their status bits unchanged.
- R10: Status latches regardless of the interrupt mask. A pin whose interrupt-mask bit is 1 does not drive `irq_o`.
- R11: `irq_o` is the OR over all pins of (status AND NOT interrupt mask), registered. It changes one clock after the status or mask change that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 93 | Asynchronous pin levels, pin n at bit n |
| reg_addr | input | 7 | Word address: family in [6:2], bank in [1:0] |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data, bit k is pin 32*bank+k |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The assertions check several relations on every cycle. The output must follow the unmasked status OR with a one-cycle delay. The non-pin bits of the last bank must never hold status. Status may only drop in a cycle after a status write. The output must be quiet and every pin masked right after reset. The bench's sweeps are needed for the rest. They establish that each pin sets its own status bit and no other, in each direction and each level polarity. They show that the disable and level-mask bits suppress detection, and that a clear loses against a still-present level. They also cover the address decode, including the unmapped family and bank holes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BANK_W = 32;

    // Word-address family codes (reg_addr[6:2])
    typedef enum logic [4:0] {
        FAM_MODE  = 5'h08,
        FAM_RISE  = 5'h09,
        FAM_FALL  = 5'h0A,
        FAM_POL   = 5'h0B,
        FAM_LMASK = 5'h0C,
        FAM_STAT  = 5'h0D,
        FAM_IMASK = 5'h10
    } fam_e;

    typedef struct packed {
        logic [BANK_W-1:0] mode;      // 0 edge, 1 level
        logic [BANK_W-1:0] rise_dis;  // 1 disables low-to-high
        logic [BANK_W-1:0] fall_dis;  // 1 disables high-to-low
        logic [BANK_W-1:0] pol;       // 1 active-low level
        logic [BANK_W-1:0] lmask;     // 1 blocks level detection
        logic [BANK_W-1:0] imask;     // 1 blocks output contribution
    } bank_cfg_t;

    // Bits of a bank that correspond to real pins
    function automatic logic [BANK_W-1:0] valid_mask(input int bank, input int npins);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++) begin
            m[i] = ((bank * BANK_W + i) < npins);
        end
        return m;
    endfunction

    // Per-pin detection on a whole bank
    function automatic logic [BANK_W-1:0] detect_hits(
        input bank_cfg_t         cfg,
        input logic [BANK_W-1:0] cur,
        input logic [BANK_W-1:0] prev
    );
        logic [BANK_W-1:0] edge_hit;
        logic [BANK_W-1:0] lvl_hit;
        edge_hit = (~cfg.rise_dis & cur & ~prev) | (~cfg.fall_dis & ~cur & prev);
        lvl_hit  = ~cfg.lmask & (cur ^ cfg.pol);
        return (~cfg.mode & edge_hit) | (cfg.mode & lvl_hit);
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 96
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter logic [BANK_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [4:0]        wr_fam,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] cur_i,
    input  logic [BANK_W-1:0] prev_i,
    output bank_cfg_t         cfg_o,
    output logic [BANK_W-1:0] status_o,
    output logic              pend_o
);
    bank_cfg_t         cfg_q;
    logic [BANK_W-1:0] stat_q;
    logic [BANK_W-1:0] hit;
    logic [BANK_W-1:0] clr;
    logic [BANK_W-1:0] wval;

    assign wval = wdata & VALID;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode     <= '0;
            cfg_q.rise_dis <= VALID;
            cfg_q.fall_dis <= VALID;
            cfg_q.pol      <= '0;
            cfg_q.lmask    <= VALID;
            cfg_q.imask    <= VALID;
        end else if (wr_en) begin
            case (wr_fam)
                FAM_MODE:  cfg_q.mode     <= wval;
                FAM_RISE:  cfg_q.rise_dis <= wval;
                FAM_FALL:  cfg_q.fall_dis <= wval;
                FAM_POL:   cfg_q.pol      <= wval;
                FAM_LMASK: cfg_q.lmask    <= wval;
                FAM_IMASK: cfg_q.imask    <= wval;
                default:   ;
            endcase
        end
    end

    assign hit = detect_hits(cfg_q, cur_i, prev_i) & VALID;
    assign clr = (wr_en && (wr_fam == FAM_STAT)) ? wval : '0;

    // Hardware set wins over a same-cycle software clear
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr) | hit;
    end

    assign cfg_o    = cfg_q;
    assign status_o = stat_q;
    assign pend_o   = |(stat_q & ~cfg_q.imask);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 93
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [6:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [BANK_W-1:0]   reg_wdata,
    output logic [BANK_W-1:0]   reg_rdata,
    output logic                irq_o
);
    localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int PAD_W     = NUM_BANKS * BANK_W;

    logic [4:0]           fam_sel;
    logic [1:0]           bank_sel;
    logic [PAD_W-1:0]     pin_pad;
    logic [PAD_W-1:0]     cur_all;
    logic [PAD_W-1:0]     prev_all;
    logic [PAD_W-1:0]     status_all;
    logic [PAD_W-1:0]     imask_all;
    logic [NUM_BANKS-1:0] pend;
    bank_cfg_t            cfg_a  [NUM_BANKS];
    logic [BANK_W-1:0]    stat_a [NUM_BANKS];
    logic                 irq_q;

    assign fam_sel  = reg_addr[6:2];
    assign bank_sel = reg_addr[1:0];

    generate
        if (PAD_W > NUM_PINS) begin : g_pad
            assign pin_pad = {{(PAD_W-NUM_PINS){1'b0}}, pin_i};
        end else begin : g_nopad
            assign pin_pad = pin_i;
        end
    endgenerate

    gpio_irq_sync #(.W(PAD_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_pad),
        .sync_o  (cur_all),
        .prev_o  (prev_all)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam logic [BANK_W-1:0] VM = valid_mask(b, NUM_PINS);
            gpio_irq_bank #(.VALID(VM)) u_bank (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (reg_wr && (bank_sel == 2'(b))),
                .wr_fam   (fam_sel),
                .wdata    (reg_wdata),
                .cur_i    (cur_all[b*BANK_W +: BANK_W]),
                .prev_i   (prev_all[b*BANK_W +: BANK_W]),
                .cfg_o    (cfg_a[b]),
                .status_o (stat_a[b]),
                .pend_o   (pend[b])
            );
            assign status_all[b*BANK_W +: BANK_W] = stat_a[b];
            assign imask_all[b*BANK_W +: BANK_W]  = cfg_a[b].imask;
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel == 2'(b)) begin
                case (fam_sel)
                    FAM_MODE:  reg_rdata = cfg_a[b].mode;
                    FAM_RISE:  reg_rdata = cfg_a[b].rise_dis;
                    FAM_FALL:  reg_rdata = cfg_a[b].fall_dis;
                    FAM_POL:   reg_rdata = cfg_a[b].pol;
                    FAM_LMASK: reg_rdata = cfg_a[b].lmask;
                    FAM_STAT:  reg_rdata = stat_a[b];
                    FAM_IMASK: reg_rdata = cfg_a[b].imask;
                    default:   reg_rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |pend;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 93
) (
    input logic                                                     clk,
    input logic                                                     rst,
    input logic                                                     reg_wr,
    input logic [6:0]                                               reg_addr,
    input logic                                                     irq_o,
    input logic [((NUM_PINS+BANK_W-1)/BANK_W)*BANK_W-1:0]           status_all,
    input logic [((NUM_PINS+BANK_W-1)/BANK_W)*BANK_W-1:0]           imask_all
);
    localparam int NB = (NUM_PINS + BANK_W - 1) / BANK_W;

    logic [NB*BANK_W-1:0] valid_all;
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            valid_all[b*BANK_W +: BANK_W] = valid_mask(b, NUM_PINS);
        end
    end

    logic stat_wr;
    assign stat_wr = reg_wr && (reg_addr[6:2] == FAM_STAT);

    // R11: an unmasked pending status raises the output on the next clock
    a_r11_irq_follows: assert property (@(posedge clk) disable iff (rst)
        (|(status_all & ~imask_all)) |=> irq_o);

    // R11 / R10: no unmasked status means a quiet output next clock
    a_r11_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        !(|(status_all & ~imask_all)) |=> !irq_o);

    // R3: non-pin bits never hold status
    a_r3_pad_quiet: assert property (@(posedge clk) disable iff (rst)
        (status_all & ~valid_all) == '0);

    // R9: status bits only drop after a status write
    a_r9_only_write_clears: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((status_all & $past(status_all)) == $past(status_all)));

    // R1: output quiet and all pins masked right after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_o && (imask_all == valid_all)));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .irq_o      (irq_o),
    .status_all (status_all),
    .imask_all  (imask_all)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
    localparam int NP = 93;
    localparam logic [6:0] W_MODE  = 7'h20;
    localparam logic [6:0] W_RISE  = 7'h24;
    localparam logic [6:0] W_FALL  = 7'h28;
    localparam logic [6:0] W_POL   = 7'h2C;
    localparam logic [6:0] W_LMASK = 7'h30;
    localparam logic [6:0] W_STAT  = 7'h34;
    localparam logic [6:0] W_IMASK = 7'h40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = '0;
    logic [6:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [31:0] d;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(NP)) u_gpio_irq_ctrl (
        .clk (clk), .rst (rst), .pin_i (pins), .reg_addr (reg_addr),
        .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .irq_o (irq_o)
    );

    function automatic logic [31:0] vm(input int b);
        return (b < 2) ? 32'hFFFF_FFFF : 32'h1FFF_FFFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr_all(input logic [6:0] base, input logic [31:0] v);
        for (int b = 0; b < 3; b++) wr(base + 7'(b), v);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R1 / R3: reset values, pad bits of bank 2 read zero
        chk("R1 irq after reset", 32'(irq_o), 32'h0);
        for (int b = 0; b < 3; b++) begin
            rd(W_MODE  + 7'(b), d); chk("R1 mode reset", d, 32'h0);
            rd(W_RISE  + 7'(b), d); chk("R1 R3 rise reset", d, vm(b));
            rd(W_FALL  + 7'(b), d); chk("R1 R3 fall reset", d, vm(b));
            rd(W_POL   + 7'(b), d); chk("R1 pol reset", d, 32'h0);
            rd(W_LMASK + 7'(b), d); chk("R1 R3 lmask reset", d, vm(b));
            rd(W_STAT  + 7'(b), d); chk("R1 status reset", d, 32'h0);
            rd(W_IMASK + 7'(b), d); chk("R1 R3 imask reset", d, vm(b));
        end

        // R2: decode, readback and holes
        wr(W_MODE + 7'd1, 32'hA5A5_A5A5);
        rd(W_MODE + 7'd1, d); chk("R2 mode readback", d, 32'hA5A5_A5A5);
        rd(W_MODE + 7'd0, d); chk("R2 other bank untouched", d, 32'h0);
        wr(W_MODE + 7'd3, 32'hFFFF_FFFF);
        rd(W_MODE + 7'd3, d); chk("R2 bank3 reads zero", d, 32'h0);
        rd(7'h00, d); chk("R2 unmapped family", d, 32'h0);
        wr(W_MODE + 7'd2, 32'hFFFF_FFFF);
        rd(W_MODE + 7'd2, d); chk("R3 bank2 upper bits", d, 32'h1FFF_FFFF);
        wr(W_MODE + 7'd1, 32'h0);
        wr(W_MODE + 7'd2, 32'h0);

        // R4 / R6 / R9: rising-edge sweep over every pin
        wr_all(W_RISE, 32'h0);
        for (int p = 0; p < NP; p++) begin
            pins = '0; pins[p] = 1'b1;
            wait_cyc(4);
            rd(W_STAT + 7'(p / 32), d); chk("R4 rising sets own bit", d, 32'h1 << (p % 32));
            pins[p] = 1'b0;
            wait_cyc(4);
            rd(W_STAT + 7'(p / 32), d); chk("R6 falling disabled", d, 32'h1 << (p % 32));
            wr(W_STAT + 7'(p / 32), 32'h1 << (p % 32));
            rd(W_STAT + 7'(p / 32), d); chk("R9 write one clears", d, 32'h0);
        end
        chk("R10 masked during sweep", 32'(irq_o), 32'h0);
        wr_all(W_RISE, 32'hFFFF_FFFF);

        // R5 / R6: falling-edge sweep
        pins = '1;
        wait_cyc(4);
        rd(W_STAT + 7'd0, d); chk("R6 rising disabled", d, 32'h0);
        wr_all(W_FALL, 32'h0);
        for (int p = 0; p < NP; p++) begin
            pins[p] = 1'b0;
            wait_cyc(4);
            rd(W_STAT + 7'(p / 32), d); chk("R5 falling sets own bit", d, 32'h1 << (p % 32));
            pins[p] = 1'b1;
            wait_cyc(4);
            rd(W_STAT + 7'(p / 32), d); chk("R6 rising disabled", d, 32'h1 << (p % 32));
            wr(W_STAT + 7'(p / 32), 32'h1 << (p % 32));
        end
        wr_all(W_FALL, 32'hFFFF_FFFF);
        pins = '0;
        wait_cyc(4);

        // R5: both directions on pin 40 (bank 1 bit 8)
        wr(W_RISE + 7'd1, ~32'h100);
        wr(W_FALL + 7'd1, ~32'h100);
        pins[40] = 1'b1; wait_cyc(4);
        rd(W_STAT + 7'd1, d); chk("R5 both rising", d, 32'h100);
        wr(W_STAT + 7'd1, 32'h100);
        pins[40] = 1'b0; wait_cyc(4);
        rd(W_STAT + 7'd1, d); chk("R5 both falling", d, 32'h100);
        wr(W_STAT + 7'd1, 32'h100);

        // R9: zero bits leave status alone
        wr(W_RISE + 7'd1, 32'h0);
        pins[33] = 1'b1; pins[40] = 1'b1; wait_cyc(4);
        rd(W_STAT + 7'd1, d); chk("R4 two pins", d, 32'h102);
        wr(W_STAT + 7'd1, 32'h100);
        rd(W_STAT + 7'd1, d); chk("R9 partial clear", d, 32'h002);
        wr(W_STAT + 7'd1, 32'h0);
        rd(W_STAT + 7'd1, d); chk("R9 zero write", d, 32'h002);

        // R10 / R11: masking and one-cycle output latency
        chk("R10 masked status no irq", 32'(irq_o), 32'h0);
        wr(W_IMASK + 7'd1, ~32'h2);
        chk("R11 irq not yet", 32'(irq_o), 32'h0);
        wait_cyc(1);
        chk("R11 irq raised", 32'(irq_o), 32'h1);
        wr(W_STAT + 7'd1, 32'h2);
        chk("R11 irq still high", 32'(irq_o), 32'h1);
        wait_cyc(1);
        chk("R11 irq dropped", 32'(irq_o), 32'h0);
        wr(W_IMASK + 7'd1, 32'hFFFF_FFFF);
        wr(W_RISE + 7'd1, 32'hFFFF_FFFF);
        pins = '0;
        wait_cyc(4);
        wr_all(W_STAT, 32'hFFFF_FFFF);

        // R7 / R8 / R3: level mode
        wr_all(W_MODE, 32'hFFFF_FFFF);
        wr_all(W_POL, 32'hFFFF_FFFF);
        wr_all(W_LMASK, 32'h0);
        wait_cyc(2);
        for (int b = 0; b < 3; b++) begin
            rd(W_STAT + 7'(b), d); chk("R7 R3 active-low level", d, vm(b));
        end
        wr(W_STAT + 7'd0, 32'hFFFF_FFFF);
        rd(W_STAT + 7'd0, d); chk("R8 clear loses to level", d, 32'hFFFF_FFFF);
        pins = '1; wait_cyc(4);
        wr_all(W_STAT, 32'hFFFF_FFFF);
        rd(W_STAT + 7'd0, d); chk("R8 clear after level gone", d, 32'h0);
        wr_all(W_POL, 32'h0);
        wait_cyc(2);
        rd(W_STAT + 7'd2, d); chk("R7 R3 active-high level", d, 32'h1FFF_FFFF);
        wr_all(W_LMASK, 32'hFFFF_FFFF);
        wr_all(W_STAT, 32'hFFFF_FFFF);
        wait_cyc(4);
        rd(W_STAT + 7'd0, d); chk("R7 level mask blocks", d, 32'h0);
        chk("R10 irq quiet end", 32'(irq_o), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule